// File: doc/BRIEF.md
# MMC Command Line Controller

This block owns the bidirectional command wire of a MultiMediaCard slot. A host processor loads a command through a byte-wide write port: first the index byte, then four argument bytes, most significant byte first. It then raises and drops a start control. The block frames the command, appends a CRC7 checksum it computes itself, and shifts the 48-bit frame onto the wire at one bit per clock. The wire clock is generated elsewhere, and `clk` is taken to be that bit clock.

When a reply is expected, the block listens on the wire for a start bit. It gives up after a bounded number of idle cycles. Otherwise it collects a short (48-bit) or long (136-bit) reply into a receive queue, one byte per eight bits. It checks the reply checksum and the reply framing. The processor reads the stored bytes back through a byte-wide read port. Completion flags for the command phase and the reply phase hold until the next command is started.

Top module: `mmc_cmd_ctrl`

## Requirements
- R1: Up to five byte writes are accepted into the transmit queue, in this order: index byte, then argument bits 31:24, 23:16, 15:8 and 7:0. Bits 7:6 of the index byte have no effect on the frame. A sixth and later write before the queue is emptied is ignored.
- R2: The frame is 48 bits sent most significant bit first, one bit per clock: `0`, `1`, six index bits, 32 argument bits, seven CRC bits, `1`. `line_oe` is high for exactly those 48 cycles. The first bit appears on the clock edge that samples `cmd_go` low after it was high.
- R3: The CRC7 uses polynomial x^7+x^3+1 with a zero start value and covers the 40 frame bits ahead of it. An index 0, argument 0 command is therefore the bytes 40 00 00 00 00 95.
- R4: `fifo_lock` rises on the edge that first samples `cmd_go` high while idle. While it is high, writes to the transmit queue are ignored.
- R5: On the edge that sends the last frame bit, `cmd_done_flag` is set, `fifo_lock` is cleared and the transmit write position returns to the index byte.
- R6: A pulse on `tx_ptr_rst` discards the bytes loaded so far. The next write becomes the index byte again.
- R7: With `resp_en` low no reply is collected. With it high the line is watched for a `0`. If `RESP_TIMEOUT` (64) consecutive samples stay high, `resp_timeout` is set and no reply is stored.
- R8: A short reply stores 6 bytes and a long reply (`resp_long`=1) stores 17 bytes, in arrival order. `resp_rdata` shows the byte at the read position, and each `resp_rd` pulse advances it. `rx_ptr_rst` returns it to the first byte. Reading past the stored bytes gives 0.
- R9: The reply CRC7 is computed over reply bits 0 to 39 (short) or 8 to 127 (long) and compared with the seven bits ahead of the last one. On a mismatch `crc_err` is set, unless `crc_chk_off` was high when the command started.
- R10: `frame_err` is set when reply bit 1 is not `0` or the last reply bit is not `1`.
- R11: `resp_done_flag` is set on the edge that samples the last reply bit. All five result flags are cleared when the next command raises `fifo_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Write strobe for the transmit queue |
| cmd_wdata | input | 8 | Byte written to the transmit queue |
| cmd_go | input | 1 | Start control: raise, then drop |
| tx_ptr_rst | input | 1 | Reset transmit write position |
| rx_ptr_rst | input | 1 | Reset receive read position |
| resp_en | input | 1 | A reply is expected |
| resp_long | input | 1 | Reply is 136 bits instead of 48 |
| crc_chk_off | input | 1 | Skip reply CRC7 check |
| resp_rd | input | 1 | Advance receive read position |
| resp_rdata | output | 8 | Byte at receive read position |
| line_out | output | 1 | Command line drive value |
| line_oe | output | 1 | Command line drive enable |
| line_in | input | 1 | Command line sampled value |
| fifo_lock | output | 1 | Transmit queue locked |
| crc_err | output | 1 | Reply CRC7 mismatch |
| frame_err | output | 1 | Reply framing error |
| resp_timeout | output | 1 | No reply start bit seen in time |
| cmd_done_flag | output | 1 | Command frame fully sent |
| resp_done_flag | output | 1 | Reply fully received |

## Verification
Most state corruptions surface at `line_out` within one frame. A wrong transmit pointer or a missed lock shows up as a wrong byte in the 48-bit frame. A bad CRC shift shows up in bits 40 to 46. An off-by-one in the bit counter shows up as `line_oe` lasting 47 or 49 cycles. On the receive side, a bad bit index misplaces bytes in the read-back. A bad CRC region flips `crc_err` on the edge after the last reply bit. A miscounted idle window moves `resp_timeout` one cycle off the 64-sample boundary, and both 63 and 64 samples are probed.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

  localparam int FRAME_BITS = 48;
  localparam int HEAD_BITS  = 40;
  localparam logic [6:0] CRC7_POLY = 7'h09;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SEND,
    ST_WAIT,
    ST_RECV
  } cc_state_e;

  // one serial step of the x^7+x^3+1 remainder register
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_head(input logic [HEAD_BITS-1:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = HEAD_BITS - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

  function automatic logic [FRAME_BITS-1:0] cmd_frame(input logic [HEAD_BITS-1:0] head);
    return {head, crc7_head(head), 1'b1};
  endfunction

endpackage

// File: rtl/mmc_cmd_txq.sv
module mmc_cmd_txq #(
  parameter int NB = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            lock,
  input  logic            ptr_clr,
  input  logic            tx_end,
  output logic [8*NB-1:0] bytes_flat
);
  localparam int PW = $clog2(NB + 1);
  localparam logic [PW-1:0] FULL = PW'(NB);

  logic [7:0]    mem [NB];
  logic [PW-1:0] wptr;
  logic          wr_ok;

  assign wr_ok = wr && !lock && (wptr < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (ptr_clr || tx_end) begin
      wptr <= '0;
    end else if (wr_ok) begin
      mem[wptr] <= wdata;
      wptr      <= wptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign bytes_flat[8*(NB-1-g) +: 8] = mem[g];
  end

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr && !ptr_clr && !tx_end) |=> $stable(wptr)); // R4
  AST_TX_PTR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= FULL); // R1
  AST_TX_END_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> (wptr == '0)); // R5

endmodule

// File: rtl/mmc_cmd_rxq.sv
module mmc_cmd_rxq #(
  parameter int DEPTH = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wclr,
  input  logic       push,
  input  logic [7:0] pdata,
  input  logic       rclr,
  input  logic       pop,
  output logic [7:0] rdata
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic          have;

  assign have  = rptr < wptr;
  assign rdata = have ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (push && wptr < FULL) mem[wptr] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wclr)                      wptr <= '0;
      else if (push && wptr < FULL)  wptr <= wptr + 1'b1;
      if (rclr)                      rptr <= '0;
      else if (pop && have)          rptr <= rptr + 1'b1;
    end
  end

  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (wptr < FULL)); // R8
  AST_RX_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr <= FULL)); // R8

endmodule

// File: rtl/mmc_cmd_ctrl.sv
module mmc_cmd_ctrl
  import mmc_cmd_pkg::*;
#(
  parameter int TX_BYTES     = 5,
  parameter int RX_BYTES     = 17,
  parameter int SHORT_BITS   = 48,
  parameter int LONG_BITS    = 136,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_go,
  input  logic       tx_ptr_rst,
  input  logic       rx_ptr_rst,
  input  logic       resp_en,
  input  logic       resp_long,
  input  logic       crc_chk_off,
  input  logic       resp_rd,
  output logic [7:0] resp_rdata,
  output logic       line_out,
  output logic       line_oe,
  input  logic       line_in,
  output logic       fifo_lock,
  output logic       crc_err,
  output logic       frame_err,
  output logic       resp_timeout,
  output logic       cmd_done_flag,
  output logic       resp_done_flag
);
  localparam int TXW = 8 * TX_BYTES;
  localparam int BCW = $clog2(FRAME_BITS);
  localparam int IW  = $clog2(LONG_BITS + 1);
  localparam int TW  = $clog2(RESP_TIMEOUT);
  localparam logic [BCW-1:0] LAST_TX       = BCW'(FRAME_BITS - 1);
  localparam logic [IW-1:0]  SHORT_LAST    = IW'(SHORT_BITS - 1);
  localparam logic [IW-1:0]  LONG_LAST     = IW'(LONG_BITS - 1);
  localparam logic [IW-1:0]  SHORT_CRC_END = IW'(SHORT_BITS - 8);
  localparam logic [IW-1:0]  LONG_CRC_BEG  = IW'(8);
  localparam logic [IW-1:0]  LONG_CRC_END  = IW'(LONG_BITS - 8);
  localparam logic [TW-1:0]  WAIT_LAST     = TW'(RESP_TIMEOUT - 1);

  cc_state_e             state;
  logic                  go_q;
  logic [BCW-1:0]        bit_cnt;
  logic [FRAME_BITS-1:0] sr;
  logic [TW-1:0]         wait_cnt;
  logic [IW-1:0]         rx_idx;
  logic [6:0]            byte_sr;
  logic [6:0]            crc_acc;
  logic                  tbit_q;
  logic                  cfg_want, cfg_long, cfg_skip;

  logic [TXW-1:0]        tx_flat;
  logic [7:0]            head_byte;
  logic [FRAME_BITS-1:0] tx_frame;

  // named internal events
  logic          go_rise, go_fall, tx_last, rx_take, rx_last;
  logic          in_crc, wait_expire, rx_push;
  logic [IW-1:0] rx_idx_cur;

  assign go_rise     = cmd_go & ~go_q;
  assign go_fall     = ~cmd_go & go_q;
  assign tx_last     = (state == ST_SEND) && (bit_cnt == LAST_TX);
  assign rx_take     = ((state == ST_WAIT) && !line_in) || (state == ST_RECV);
  assign rx_idx_cur  = (state == ST_WAIT) ? '0 : rx_idx;
  assign rx_last     = rx_take && (rx_idx_cur == (cfg_long ? LONG_LAST : SHORT_LAST));
  assign in_crc      = cfg_long ? ((rx_idx_cur >= LONG_CRC_BEG) && (rx_idx_cur < LONG_CRC_END))
                                : (rx_idx_cur < SHORT_CRC_END);
  assign wait_expire = (state == ST_WAIT) && line_in && (wait_cnt == WAIT_LAST);
  assign rx_push     = rx_take && (rx_idx_cur[2:0] == 3'b111);

  // frame head: start and transmission bits replace index bits 7:6
  assign head_byte = (tx_flat[TXW-1 -: 8] & 8'h3F) | 8'h40;
  assign tx_frame  = cmd_frame({head_byte, tx_flat[TXW-9 -: 32]});

  assign line_out = sr[FRAME_BITS-1];
  assign line_oe  = (state == ST_SEND);

  mmc_cmd_txq #(.NB(TX_BYTES)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cmd_wr),
    .wdata      (cmd_wdata),
    .lock       (fifo_lock),
    .ptr_clr    (tx_ptr_rst),
    .tx_end     (tx_last),
    .bytes_flat (tx_flat)
  );

  mmc_cmd_rxq #(.DEPTH(RX_BYTES)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .wclr  (tx_last && cfg_want),
    .push  (rx_push),
    .pdata ({byte_sr, line_in}),
    .rclr  (rx_ptr_rst),
    .pop   (resp_rd),
    .rdata (resp_rdata)
  );

  // control and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      go_q           <= 1'b0;
      bit_cnt        <= '0;
      sr             <= '1;
      wait_cnt       <= '0;
      fifo_lock      <= 1'b0;
      crc_err        <= 1'b0;
      frame_err      <= 1'b0;
      resp_timeout   <= 1'b0;
      cmd_done_flag  <= 1'b0;
      resp_done_flag <= 1'b0;
      cfg_want       <= 1'b0;
      cfg_long       <= 1'b0;
      cfg_skip       <= 1'b0;
    end else begin
      go_q <= cmd_go;
      case (state)
        ST_IDLE: if (go_rise) begin
          state          <= ST_ARMED;
          fifo_lock      <= 1'b1;
          crc_err        <= 1'b0;
          frame_err      <= 1'b0;
          resp_timeout   <= 1'b0;
          cmd_done_flag  <= 1'b0;
          resp_done_flag <= 1'b0;
        end
        ST_ARMED: if (go_fall) begin
          state    <= ST_SEND;
          sr       <= tx_frame;
          bit_cnt  <= '0;
          cfg_want <= resp_en;
          cfg_long <= resp_long;
          cfg_skip <= crc_chk_off;
        end
        ST_SEND: begin
          sr      <= {sr[FRAME_BITS-2:0], 1'b1};
          bit_cnt <= bit_cnt + 1'b1;
          if (tx_last) begin
            fifo_lock     <= 1'b0;
            cmd_done_flag <= 1'b1;
            wait_cnt      <= '0;
            state         <= cfg_want ? ST_WAIT : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (!line_in) begin
            state <= ST_RECV;
          end else if (wait_expire) begin
            state        <= ST_IDLE;
            resp_timeout <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_RECV: if (rx_last) begin
          state          <= ST_IDLE;
          resp_done_flag <= 1'b1;
          crc_err        <= !cfg_skip && (byte_sr != crc_acc);
          frame_err      <= tbit_q | ~line_in;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // reply deserializer and running CRC
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_idx  <= '0;
      byte_sr <= '0;
      crc_acc <= '0;
      tbit_q  <= 1'b0;
    end else if (rx_take) begin
      byte_sr <= {byte_sr[5:0], line_in};
      rx_idx  <= rx_idx_cur + 1'b1;
      if (in_crc) crc_acc <= crc7_step(crc_acc, line_in);
      if (rx_idx_cur == IW'(1)) tbit_q <= line_in;
    end else if (tx_last) begin
      rx_idx  <= '0;
      crc_acc <= '0;
    end
  end

  AST_LOCK_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) |-> fifo_lock); // R4
  AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out); // R2
  AST_DONE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done_flag) |-> !fifo_lock); // R5
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_timeout && resp_done_flag)); // R7
  AST_NO_RX_WHILE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !rx_push); // R7
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_lock) |-> (!cmd_done_flag && !resp_done_flag && !resp_timeout)); // R11

endmodule

// File: tb/mmc_cmd_ctrl_bench.sv
module mmc_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 64;
  localparam int NVEC       = 7;

  // {idx[42:37], arg[36:5], want[4], long[3], skip[2], badcrc[1], badframe[0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {6'd0,  32'h0000_0000, 5'b00000},
    {6'd17, 32'h1234_5678, 5'b10000},
    {6'd2,  32'h0000_0000, 5'b11000},
    {6'd13, 32'hDEAD_BEEF, 5'b10010},
    {6'd41, 32'h00FF_8000, 5'b10110},
    {6'd3,  32'hA5A5_A5A5, 5'b10001},
    {6'd9,  32'h0F0F_3C3C, 5'b11010}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_go = 0, tx_ptr_rst = 0, rx_ptr_rst = 0;
  logic resp_en = 0, resp_long = 0, crc_chk_off = 0, resp_rd = 0;
  logic [7:0] cmd_wdata = 0;
  logic line_in = 1'b1;
  logic [7:0] resp_rdata;
  logic line_out, line_oe, fifo_lock, crc_err, frame_err, resp_timeout;
  logic cmd_done_flag, resp_done_flag;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_cmd_ctrl u_mmc_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_go(cmd_go), .tx_ptr_rst(tx_ptr_rst), .rx_ptr_rst(rx_ptr_rst),
    .resp_en(resp_en), .resp_long(resp_long), .crc_chk_off(crc_chk_off),
    .resp_rd(resp_rd), .resp_rdata(resp_rdata), .line_out(line_out),
    .line_oe(line_oe), .line_in(line_in), .fifo_lock(fifo_lock),
    .crc_err(crc_err), .frame_err(frame_err), .resp_timeout(resp_timeout),
    .cmd_done_flag(cmd_done_flag), .resp_done_flag(resp_done_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // polynomial long division by 0x89 over the n low bits of m
  function automatic logic [6:0] ref_crc(input logic [127:0] m, input int n);
    logic [134:0] r;
    r = {m, 7'b0};
    for (int i = n + 6; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, ref_crc({88'b0, h}, 40), 1'b1};
  endfunction

  task automatic wr_byte(input logic [7:0] b);
    cmd_wr = 1; cmd_wdata = b;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic load_cmd(input logic [5:0] idx, input logic [31:0] arg);
    wr_byte({2'b11, idx});      // R1 bits 7:6 of index byte have no effect
    for (int k = 3; k >= 0; k--) wr_byte(arg[8*k +: 8]);
  endtask

  task automatic go_up();
    cmd_go = 1;
    @(negedge clk);
    chk("R4 lock after go", 64'(fifo_lock), 64'd1);
    chk("R11 flags cleared", {61'b0, cmd_done_flag, resp_done_flag, resp_timeout}, 64'd0);
  endtask

  task automatic go_down_capture(input logic [47:0] exp, input string tag);
    logic [47:0] got;
    int oe_bad;
    oe_bad = 0;
    cmd_go = 0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      got[47 - i] = line_out;
      if (line_oe !== 1'b1) oe_bad++;
    end
    chk({tag, " R2 frame"}, 64'(got), 64'(exp));
    chk({tag, " R2 oe during frame"}, 64'(oe_bad), 64'd0);
    @(negedge clk);
    chk({tag, " R2 oe after frame"}, 64'(line_oe), 64'd0);
    chk({tag, " R5 done/lock"}, {62'b0, cmd_done_flag, fifo_lock}, 64'b10);
  endtask

  task automatic drive_resp(input logic [135:0] rsp, input int len);
    for (int i = 0; i < len; i++) begin
      line_in = rsp[len - 1 - i];
      @(negedge clk);
    end
    line_in = 1'b1;
  endtask

  task automatic read_back(input logic [135:0] rsp, input int nbytes);
    rx_ptr_rst = 1;
    @(negedge clk);
    rx_ptr_rst = 0;
    for (int b = 0; b < nbytes; b++) begin
      chk("R8 reply byte", 64'(resp_rdata), 64'(rsp[8*(nbytes - 1 - b) +: 8]));
      resp_rd = 1;
      @(negedge clk);
      resp_rd = 0;
    end
    chk("R8 read past end", 64'(resp_rdata), 64'd0);
  endtask

  task automatic run_vec(input logic [42:0] v);
    logic [5:0] idx; logic [31:0] arg;
    logic want, lng, skip, bcrc, bfrm;
    logic [135:0] rsp;
    logic [119:0] pay;
    logic [39:0] sh;
    int len;
    {idx, arg, want, lng, skip, bcrc, bfrm} = v;
    resp_en = want; resp_long = lng; crc_chk_off = skip;
    load_cmd(idx, arg);
    go_up();
    go_down_capture(ref_frame(idx, arg), "vec");
    if (!want) begin
      repeat (4) @(negedge clk);
      chk("R7 no reply collected", {62'b0, resp_done_flag, line_oe}, 64'd0);
    end else begin
      if (lng) begin
        pay = {arg, ~arg, arg, ~arg[23:0]};
        rsp = {8'h3F, pay, ref_crc({8'b0, pay}, 120) ^ {6'b0, bcrc}, ~bfrm};
        len = 136;
      end else begin
        sh  = {2'b00, idx, arg ^ 32'hFFFF_0000};
        rsp = {88'b0, sh, ref_crc({88'b0, sh}, 40) ^ {6'b0, bcrc}, ~bfrm};
        len = 48;
      end
      drive_resp(rsp, len);
      chk("R11 reply done", 64'(resp_done_flag), 64'd1);
      chk("R9 crc flag", 64'(crc_err), 64'(bcrc & ~skip));
      chk("R10 frame flag", 64'(frame_err), 64'(bfrm));
      chk("R7 no timeout", 64'(resp_timeout), 64'd0);
      read_back(rsp, len / 8);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset idle line", {61'b0, line_oe, line_out, fifo_lock}, 64'b010);
    chk("R11 reset flags", {59'b0, crc_err, frame_err, resp_timeout, cmd_done_flag, resp_done_flag}, 64'd0);
    chk("R8 reset read", 64'(resp_rdata), 64'd0);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

    // R3 known vector
    resp_en = 0;
    load_cmd(6'd0, 32'h0);
    go_up();
    go_down_capture(48'h4000_0000_0095, "R3 known crc");

    // R1 sixth write ignored
    load_cmd(6'd24, 32'hCAFE_F00D);
    wr_byte(8'h77);
    go_up();
    go_down_capture(ref_frame(6'd24, 32'hCAFE_F00D), "R1 overflow");

    // R6 pointer reset aborts partial load
    wr_byte(8'h11); wr_byte(8'h22);
    tx_ptr_rst = 1; @(negedge clk); tx_ptr_rst = 0;
    load_cmd(6'd55, 32'h0102_0304);
    go_up();
    go_down_capture(ref_frame(6'd55, 32'h0102_0304), "R6 ptr reset");

    // R4 writes during lock ignored: bytes 2..4 keep previous contents
    load_cmd(6'd5, 32'h1122_3344);
    go_up();
    go_down_capture(ref_frame(6'd5, 32'h1122_3344), "R4 setup");
    wr_byte(8'h06); wr_byte(8'hAA);
    go_up();
    wr_byte(8'hBB); wr_byte(8'hCC); wr_byte(8'hDD);
    go_down_capture(ref_frame(6'd6, 32'hAA22_3344), "R4 locked writes");

    // R7 timeout boundary
    resp_en = 1; resp_long = 0;
    load_cmd(6'd1, 32'h8000_0000);
    go_up();
    go_down_capture(ref_frame(6'd1, 32'h8000_0000), "R7 setup");
    repeat (TIMEOUT - 1) @(negedge clk);
    chk("R7 no timeout at 63", 64'(resp_timeout), 64'd0);
    @(negedge clk);
    chk("R7 timeout at 64", {62'b0, resp_timeout, resp_done_flag}, 64'b10);

    // R11 next command clears timeout (checked inside go_up)
    resp_en = 0;
    load_cmd(6'd7, 32'h0);
    go_up();
    go_down_capture(ref_frame(6'd7, 32'h0), "R11 clear");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule